// File: doc/BRIEF.md
# Reconfiguration Bus Ownership Arbiter

This block sits between a user reconfiguration port (address, read, write, writedata, readdata, waitrequest) and a shared configuration-register bus that an internal calibration engine also drives. It keeps track of whether the calibration engine or the user controls the bus, separately for the PLL and for the channel. It stalls user accesses to the configuration-bus address region while the engine holds the bus, and it publishes ownership and calibration-busy state through two read-only capability registers. Calibration is modelled as a countdown of `CAL_CYCLES` clock cycles per phase. The PLL busy flag is raised during the PLL phase, and the TX and RX busy flags are raised during the channel phase.

Software hands the bus back to the engine with a write to offset 0x000, and that write starts a new calibration run. The code that is accepted depends on the calibration enable register at offset 0x100: 0x01 is accepted when at least one enable bit is set, and 0x03 is accepted when none is set. The `SEP_STATUS` parameter selects a mode in which waitrequest never stalls for ownership. In that mode, software polls the ownership bits instead, and configuration-bus accesses made while the engine owns the bus have no effect.

The sequencer has three states. `ST_PLL` is the PLL calibration phase, `ST_CHAN` is the channel calibration phase, and `ST_USER` means the user owns the bus. The transitions are:
- reset → `ST_PLL`, with every enable set.
- `ST_PLL` → `ST_CHAN` when the phase count expires.
- `ST_CHAN` → `ST_USER` when the phase count expires.
- `ST_USER` → `ST_PLL` on an accepted hand-back while the PLL enable is set.
- `ST_USER` → `ST_CHAN` on an accepted hand-back while the PLL enable is clear.

Top module: `reconfig_bus_arbiter`

## Requirements
- R1: After reset the engine owns both the PLL and the channel. The PLL phase comes first, with pll_cal_busy high for exactly CAL_CYCLES cycles. It is followed by a channel phase in which tx_cal_busy and rx_cal_busy are high for exactly CAL_CYCLES cycles. The user then owns the bus.
- R2: A run consists of a PLL phase only when enable bit 0 (PLL) is set, followed by a channel phase. Each phase lasts CAL_CYCLES cycles. During the channel phase tx_cal_busy follows enable bit 1 and rx_cal_busy follows enable bit 2. pll_cal_busy is never high together with tx_cal_busy or rx_cal_busy.
- R3: When SEP_STATUS=0, waitrequest is high for every address below 0x280 (the configuration-bus region) while the engine owns the channel. It is low there while the user owns the bus.
- R4: Addresses 0x280 to 0x3FF never stall. This range covers the capability registers, the unmapped range 0x282 to 0x2FF and the streamer region 0x300 to 0x3FF.
- R5: A user write to the configuration-bus region is held off while the engine owns the bus and is not lost. It completes in the first cycle of user ownership.
- R6: A write whose bits [7:0] are 0x01 to offset 0x000 while any enable bit is set starts a run. A write whose bits [7:0] are 0x03 while no enable bit is set also starts a run; that run has only a channel phase with no busy flag raised.
- R7: A hand-back write with any other value in bits [7:0], 0x01 with no enable set, or 0x03 with any enable set, is ignored: the user keeps the bus.
- R8: Reads of 0x280 return bit 0 = pll_cal_busy and bit 2 = 1 while the engine owns the PLL. Reads of 0x281 return bit 0 = tx_cal_busy, bit 1 = rx_cal_busy and bit 2 = 1 while the engine owns the channel. All other bits read zero.
- R9: Offset 0x100 holds the enable bits [2:0] (PLL, TX, RX), which reset to 0b111 and are written from writedata[2:0]. Upper bits read zero. Reads of offset 0x000, of unmapped addresses and of the streamer region return zero.
- R10: When SEP_STATUS=1, waitrequest is never asserted. Configuration-bus writes made while the engine owns the bus are dropped, and reads made then return zero. The capability ownership bits still report the engine.
- R11: Writes to the capability registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| address | input | ADDR_W | User word address |
| read | input | 1 | Read request |
| write | input | 1 | Write request |
| writedata | input | DATA_W | Write data |
| readdata | output | DATA_W | Read data, valid while read is high and waitrequest is low |
| waitrequest | output | 1 | Stall for the current address |
| pll_cal_busy | output | 1 | PLL calibration in progress |
| tx_cal_busy | output | 1 | TX calibration in progress |
| rx_cal_busy | output | 1 | RX calibration in progress |

## Verification
A sequencer stuck in the wrong state, or a phase counter that is off by one, shows up at the next busy edge: the number of cycles a busy flag stays high, or the number of cycles waitrequest stays high on the configuration region, differs from CAL_CYCLES or 2*CAL_CYCLES. A wrong enable register or a wrong hand-back decode shows up on the cycle after the hand-back write. At that point the capability ownership bit and the busy pattern read back one cycle after acceptance no longer match the value computed from the written code and enables. An address-region decode fault shows as a stall, or a missing stall, on the same cycle that the address is presented.

// File: rtl/recfg_arb_pkg.sv
package recfg_arb_pkg;

    typedef enum logic [1:0] {
        ST_USER = 2'd0,
        ST_PLL  = 2'd1,
        ST_CHAN = 2'd2
    } cal_state_t;

    typedef enum logic [1:0] {
        RG_CFG    = 2'd0,
        RG_CAP    = 2'd1,
        RG_STREAM = 2'd2,
        RG_NONE   = 2'd3
    } region_t;

    typedef struct packed {
        logic rx;
        logic tx;
        logic pll;
    } cal_en_t;

    localparam int OFS_HANDBACK = 'h000;
    localparam int OFS_CALEN    = 'h100;
    localparam int OFS_CAP_PLL  = 'h280;
    localparam int OFS_CAP_CH   = 'h281;
    localparam int OFS_STREAM   = 'h300;

    localparam logic [7:0] CODE_WITH_CAL = 8'h01;
    localparam logic [7:0] CODE_NO_CAL   = 8'h03;

endpackage

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import recfg_arb_pkg::*;
#(
    parameter int CAL_CYCLES = 64
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  cal_en_t start_en,
    output logic    pll_busy,
    output logic    tx_busy,
    output logic    rx_busy,
    output logic    pll_eng,
    output logic    chan_eng
);

    localparam int CNT_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CAL_CYCLES - 1);

    cal_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    cal_en_t          run_en_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_USER: if (start) state_d = start_en.pll ? ST_PLL : ST_CHAN;
            ST_PLL:  if (cnt_q == '0) state_d = ST_CHAN;
            ST_CHAN: if (cnt_q == '0) state_d = ST_USER;
            default: state_d = ST_USER;
        endcase
    end

    // state register with phase counter and latched run enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_PLL;
            cnt_q    <= LOAD;
            run_en_q <= '1;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= LOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (state_q == ST_USER && start) begin
                run_en_q <= start_en;
            end
        end
    end

    // outputs per state
    always_comb begin
        pll_busy = 1'b0;
        tx_busy  = 1'b0;
        rx_busy  = 1'b0;
        pll_eng  = 1'b0;
        chan_eng = 1'b0;
        unique case (state_q)
            ST_PLL: begin
                pll_busy = run_en_q.pll;
                pll_eng  = 1'b1;
                chan_eng = 1'b1;
            end
            ST_CHAN: begin
                tx_busy  = run_en_q.tx;
                rx_busy  = run_en_q.rx;
                chan_eng = 1'b1;
            end
            default: begin
                chan_eng = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/addr_region_sel.sv
module addr_region_sel
    import recfg_arb_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int SEP_STATUS = 0
) (
    input  logic [ADDR_W-1:0] address,
    input  logic              chan_eng,
    output region_t           region,
    output logic              waitrequest
);

    localparam logic SEP_BIT = (SEP_STATUS != 0);

    logic cfg_wait;
    logic stream_wait;

    always_comb begin
        if (address < ADDR_W'(OFS_CAP_PLL)) begin
            region = RG_CFG;
        end else if (address == ADDR_W'(OFS_CAP_PLL) || address == ADDR_W'(OFS_CAP_CH)) begin
            region = RG_CAP;
        end else if (address >= ADDR_W'(OFS_STREAM)) begin
            region = RG_STREAM;
        end else begin
            region = RG_NONE;
        end
    end

    // per-source stall terms
    assign cfg_wait    = chan_eng & ~SEP_BIT;
    assign stream_wait = 1'b0;

    always_comb begin
        unique case (region)
            RG_CFG:    waitrequest = cfg_wait;
            RG_STREAM: waitrequest = stream_wait;
            default:   waitrequest = 1'b0;
        endcase
    end

endmodule

// File: rtl/cal_regfile.sv
module cal_regfile
    import recfg_arb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] address,
    input  logic              read,
    input  logic              write,
    input  logic [DATA_W-1:0] writedata,
    input  logic              waitrequest,
    input  region_t           region,
    input  logic              pll_busy,
    input  logic              tx_busy,
    input  logic              rx_busy,
    input  logic              pll_eng,
    input  logic              chan_eng,
    output logic [DATA_W-1:0] readdata,
    output logic              start,
    output cal_en_t           cal_en
);

    logic    wr_ok;
    logic    code_ok;
    cal_en_t en_q;
    logic    unused_wd;

    assign unused_wd = ^writedata[DATA_W-1:8];

    assign wr_ok = write && !waitrequest && region == RG_CFG && !chan_eng;

    assign code_ok = (writedata[7:0] == CODE_WITH_CAL && en_q != '0)
                  || (writedata[7:0] == CODE_NO_CAL && en_q == '0);

    assign start  = wr_ok && address == ADDR_W'(OFS_HANDBACK) && code_ok;
    assign cal_en = en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '1;
        end else if (wr_ok && address == ADDR_W'(OFS_CALEN)) begin
            en_q <= cal_en_t'(writedata[2:0]);
        end
    end

    always_comb begin
        readdata = '0;
        if (read) begin
            unique case (region)
                RG_CFG: begin
                    if (!chan_eng && address == ADDR_W'(OFS_CALEN)) begin
                        readdata[2:0] = en_q;
                    end
                end
                RG_CAP: begin
                    if (address == ADDR_W'(OFS_CAP_PLL)) begin
                        readdata[2:0] = {pll_eng, 1'b0, pll_busy};
                    end else begin
                        readdata[2:0] = {chan_eng, rx_busy, tx_busy};
                    end
                end
                default: readdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/reconfig_bus_arbiter.sv
module reconfig_bus_arbiter
    import recfg_arb_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int CAL_CYCLES = 64,
    parameter int SEP_STATUS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] address,
    input  logic              read,
    input  logic              write,
    input  logic [DATA_W-1:0] writedata,
    output logic [DATA_W-1:0] readdata,
    output logic              waitrequest,
    output logic              pll_cal_busy,
    output logic              tx_cal_busy,
    output logic              rx_cal_busy
);

    region_t region;
    cal_en_t cal_en;
    logic    start;
    logic    pll_eng;
    logic    chan_eng;

    cal_sequencer #(
        .CAL_CYCLES(CAL_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_en (cal_en),
        .pll_busy (pll_cal_busy),
        .tx_busy  (tx_cal_busy),
        .rx_busy  (rx_cal_busy),
        .pll_eng  (pll_eng),
        .chan_eng (chan_eng)
    );

    addr_region_sel #(
        .ADDR_W     (ADDR_W),
        .SEP_STATUS (SEP_STATUS)
    ) u_sel (
        .address     (address),
        .chan_eng    (chan_eng),
        .region      (region),
        .waitrequest (waitrequest)
    );

    cal_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .address     (address),
        .read        (read),
        .write       (write),
        .writedata   (writedata),
        .waitrequest (waitrequest),
        .region      (region),
        .pll_busy    (pll_cal_busy),
        .tx_busy     (tx_cal_busy),
        .rx_busy     (rx_cal_busy),
        .pll_eng     (pll_eng),
        .chan_eng    (chan_eng),
        .readdata    (readdata),
        .start       (start),
        .cal_en      (cal_en)
    );

endmodule

// File: rtl/reconfig_bus_arbiter_chk.sv
module reconfig_bus_arbiter_chk #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int SEP_STATUS = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] address,
    input logic              read,
    input logic              write,
    input logic [DATA_W-1:0] writedata,
    input logic [DATA_W-1:0] readdata,
    input logic              waitrequest,
    input logic              pll_cal_busy,
    input logic              tx_cal_busy,
    input logic              rx_cal_busy
);

    localparam bit SEP_ON = (SEP_STATUS != 0);

    // R3
    cfg_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!SEP_ON && (pll_cal_busy || tx_cal_busy || rx_cal_busy)
         && address < ADDR_W'('h280)) |-> waitrequest);

    // R4
    high_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (address >= ADDR_W'('h280)) |-> !waitrequest);

    // R2
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_cal_busy |-> !(tx_cal_busy || rx_cal_busy));

    // R10
    sep_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SEP_ON |-> !waitrequest);

    // R8
    cap_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (read && address == ADDR_W'('h281)) |-> readdata[1:0] == {rx_cal_busy, tx_cal_busy});

    // R9
    rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read |-> readdata[DATA_W-1:3] == '0);

    // R6
    pll_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_cal_busy) |-> $past(write && !waitrequest && address == '0
                                      && writedata[7:0] == 8'h01));

    // R6
    chan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_cal_busy) && !$past(pll_cal_busy))
        |-> $past(write && !waitrequest && address == '0));

endmodule

bind reconfig_bus_arbiter reconfig_bus_arbiter_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SEP_STATUS (SEP_STATUS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .address      (address),
    .read         (read),
    .write        (write),
    .writedata    (writedata),
    .readdata     (readdata),
    .waitrequest  (waitrequest),
    .pll_cal_busy (pll_cal_busy),
    .tx_cal_busy  (tx_cal_busy),
    .rx_cal_busy  (rx_cal_busy)
);

// File: tb/reconfig_bus_arbiter_tb.sv
`timescale 1ns/1ps
module reconfig_bus_arbiter_tb;

    localparam int AW = 10;
    localparam int DW = 32;
    localparam int C  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] address = '0;
    logic          read = 1'b0, write = 1'b0;
    logic [DW-1:0] writedata = '0;
    logic [DW-1:0] readdata;
    logic          waitrequest, pll_cal_busy, tx_cal_busy, rx_cal_busy;

    logic [AW-1:0] s_address = '0;
    logic          s_read = 1'b0, s_write = 1'b0;
    logic [DW-1:0] s_writedata = '0;
    logic [DW-1:0] s_readdata;
    logic          s_waitrequest, s_pll, s_tx, s_rx;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    reconfig_bus_arbiter #(.ADDR_W(AW), .DATA_W(DW), .CAL_CYCLES(C), .SEP_STATUS(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .address(address), .read(read), .write(write),
        .writedata(writedata), .readdata(readdata), .waitrequest(waitrequest),
        .pll_cal_busy(pll_cal_busy), .tx_cal_busy(tx_cal_busy), .rx_cal_busy(rx_cal_busy));

    reconfig_bus_arbiter #(.ADDR_W(AW), .DATA_W(DW), .CAL_CYCLES(C), .SEP_STATUS(1)) u_dut_sep (
        .clk(clk), .rst_n(rst_n), .address(s_address), .read(s_read), .write(s_write),
        .writedata(s_writedata), .readdata(s_readdata), .waitrequest(s_waitrequest),
        .pll_cal_busy(s_pll), .tx_cal_busy(s_tx), .rx_cal_busy(s_rx));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_go(input logic [31:0] wd, input logic [2:0] en);
        return (wd[7:0] == 8'h01 && en != 3'd0) || (wd[7:0] == 8'h03 && en == 3'd0);
    endfunction

    function automatic logic [31:0] exp_cap_pll(input logic go, input logic [2:0] en);
        return (go && en[0]) ? 32'h5 : 32'h0;
    endfunction

    function automatic logic [31:0] exp_cap_ch(input logic go, input logic [2:0] en);
        if (!go) return 32'h0;
        if (en[0]) return 32'h4;
        return {29'd0, 1'b1, en[2], en[1]};
    endfunction

    function automatic int exp_run_len(input logic go, input logic [2:0] en);
        if (!go) return 0;
        return en[0] ? 2 * C : C;
    endfunction

    function automatic logic [31:0] exp_user_read(input logic [AW-1:0] a, input logic [2:0] en);
        return (a == AW'('h100)) ? {29'd0, en} : 32'h0;
    endfunction

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, output int waits);
        @(negedge clk);
        address = a; writedata = d; write = 1'b1; waits = 0;
        #0.2;
        while (waitrequest) begin @(negedge clk); #0.2; waits++; end
        @(negedge clk);
        write = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d, output int waits);
        @(negedge clk);
        address = a; read = 1'b1; waits = 0;
        #0.2;
        while (waitrequest) begin @(negedge clk); #0.2; waits++; end
        d = readdata;
        @(negedge clk);
        read = 1'b0;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [31:0] d, output logic wr);
        address = a; read = 1'b1;
        #0.2;
        d = readdata; wr = waitrequest;
        read = 1'b0;
    endtask

    task automatic wait_run(output int n);
        n = 0;
        forever begin
            address = '0;
            #0.2;
            if (!waitrequest) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic s_wr(input logic [AW-1:0] a, input logic [31:0] d, output int waits);
        @(negedge clk);
        s_address = a; s_writedata = d; s_write = 1'b1; waits = 0;
        #0.2;
        while (s_waitrequest) begin @(negedge clk); #0.2; waits++; end
        @(negedge clk);
        s_write = 1'b0;
    endtask

    task automatic s_peek(input logic [AW-1:0] a, output logic [31:0] d, output logic wr);
        s_address = a; s_read = 1'b1;
        #0.2;
        d = s_readdata; wr = s_waitrequest;
        s_read = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        wr;
        int          w;
        int          n;
        logic [2:0]  en;
        logic [31:0] wd;
        logic        go;
        logic [AW-1:0] addrs [6];
        addrs = '{AW'('h100), AW'('h280), AW'('h281), AW'('h2C0), AW'('h3F0), AW'('h050)};
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        peek(AW'('h280), d, wr); chk("R1 cap pll at reset", d, 32'h5);
        peek(AW'('h281), d, wr); chk("R1 cap chan at reset", d, 32'h4);
        n = 0;
        while (pll_cal_busy) begin n++; @(negedge clk); end
        chk("R1 pll phase length", n, C);
        chk("R1 tx/rx busy after pll", {tx_cal_busy, rx_cal_busy}, 2'b11);
        n = 0;
        while (tx_cal_busy) begin n++; @(negedge clk); end
        chk("R1 chan phase length", n, C);
        address = '0; #0.2;
        chk("R3 cfg no stall for user", waitrequest, 1'b0);

        // R9: enable register and unmapped reads
        bus_write(AW'('h100), 32'hFFFF_FFFD, w);
        bus_read(AW'('h100), d, w);
        chk("R9 enable readback", d, 32'h5);
        chk("R9 enable read no wait", w, 0);
        // R11: capability write ignored
        bus_write(AW'('h281), 32'hFFFF_FFFF, w);
        @(negedge clk);
        peek(AW'('h281), d, wr); chk("R11 cap write ignored", d, 32'h0);
        peek(AW'('h2C0), d, wr); chk("R9 unmapped reads zero", d, 32'h0);

        // R7: mismatched hand-back codes
        bus_write(AW'('h100), 32'h0, w);
        bus_write(AW'('h000), 32'h1, w);
        peek(AW'('h281), d, wr); chk("R7 0x01 with no enables ignored", d, 32'h0);
        bus_write(AW'('h100), 32'h3, w);
        bus_write(AW'('h000), 32'h3, w);
        peek(AW'('h281), d, wr); chk("R7 0x03 with enables ignored", d, 32'h0);
        bus_write(AW'('h000), 32'h2, w);
        peek(AW'('h281), d, wr); chk("R7 0x02 ignored", d, 32'h0);

        // R6 + R5: channel-only run, stalled write completes
        bus_write(AW'('h100), 32'h6, w);
        bus_write(AW'('h000), 32'h1, w);
        peek(AW'('h280), d, wr); chk("R6 pll not owned in chan-only run", d, 32'h0);
        peek(AW'('h281), d, wr); chk("R2 tx+rx busy chan run", d, 32'h7);
        bus_write(AW'('h100), 32'h1, w);
        chk("R5 stalled write wait count", w, C - 1);
        chk("R5 completes after run", tx_cal_busy, 1'b0);
        bus_read(AW'('h100), d, w);
        chk("R5 stalled write landed", d, 32'h1);

        // R4 + R3 during a PLL run
        bus_write(AW'('h000), 32'h1, w);
        peek(AW'('h3A5), d, wr); chk("R4 streamer no stall", wr, 1'b0);
        peek(AW'('h280), d, wr); chk("R8 cap pll during run", d, 32'h5);
        peek(AW'('h2C0), d, wr); chk("R4 unmapped no stall", wr, 1'b0);
        peek(AW'('h010), d, wr); chk("R3 cfg stall while engine owns", wr, 1'b1);
        wait_run(n);
        chk("R2 pll+chan run length", n, 2 * C);

        // random mix: R6 R7 R8 R2 R9
        for (int i = 0; i < 40; i++) begin
            en = 3'($urandom);
            case ($urandom % 4)
                0: wd = 32'h1;
                1: wd = 32'h3;
                2: wd = $urandom & 32'hFFF;
                default: wd = ($urandom & 32'hFFFF_FF00) | 32'h1;
            endcase
            bus_write(AW'('h100), {29'd0, en}, w);
            begin
                logic [AW-1:0] ra;
                ra = addrs[$urandom % 6];
                bus_read(ra, d, w);
                chk("R9 random user read", d, exp_user_read(ra, en));
            end
            go = exp_go(wd, en);
            bus_write(AW'('h000), wd, w);
            peek(AW'('h280), d, wr); chk("R8 random cap pll", d, exp_cap_pll(go, en));
            peek(AW'('h281), d, wr); chk("R6 random cap chan", d, exp_cap_ch(go, en));
            wait_run(n);
            chk("R2 random run length", n, exp_run_len(go, en));
        end

        // R10: separate-status instance
        s_wr(AW'('h000), 32'h1, w);
        chk("R10 hand-back no wait", w, 0);
        s_peek(AW'('h281), d, wr); chk("R10 ownership bit set", d, 32'h4);
        s_peek(AW'('h010), d, wr); chk("R10 cfg no stall", wr, 1'b0);
        s_wr(AW'('h100), 32'h2, w);
        chk("R10 write during engine no wait", w, 0);
        s_peek(AW'('h100), d, wr); chk("R10 read during engine zero", d, 32'h0);
        repeat (2 * C + 4) @(negedge clk);
        s_peek(AW'('h281), d, wr); chk("R10 ownership returned", d, 32'h0);
        s_peek(AW'('h100), d, wr); chk("R10 dropped write", d, 32'h7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule